// File: doc/BRIEF.md
# Configuration Memory Integrity Supervisor

This block supervises the non-volatile configuration store of a bus-managed power controller. Each time the store is loaded, after a power-on reset or on a reload request, it asks an external CRC engine to verify the contents. It then waits for a done/ok handshake. A passing check releases the regulator's run output. A failing check raises the memory-fault status bits, pulls the active-low alert output, keeps run low, and lets the device answer an extra recovery bus address.

Recovery is a store command followed by a clear-faults request, or by a write of one to the CRC-error bit. Either request starts a second verification. If that second check also fails, the fault is permanent: the supervisor ignores every later command until the next power-on reset.

A die-temperature monitor works alongside the state machine and adds hysteresis. When the die is hot it locks out memory write operations. Reloads and soft resets still pass through, and each blocked command is dropped with a one-cycle reject pulse.

Top module: `nvm_guard`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `run_en`=0, `alert_n`=1, `crc_err_flag`=0 and `nvm_locked`=0. `crc_start` is 1 in the first cycle after reset is released.
- R2: A `crc_done` pulse with `crc_ok`=1 during a check sets `run_en`=1 and `crc_err_flag`=0 one cycle later. `run_en` is 1 only in this passing state.
- R3: A `crc_done` pulse with `crc_ok`=0 sets `crc_err_flag`=1, `cml_flag`=1, `alert_n`=0, `recov_addr_en`=1 and `run_en`=0 one cycle later.
- R4: `addr_hit` is combinational. It is 1 for 7'h5A, 7'h5B and `OWN_ADDR` at all times, and for 7'h7C only while `recov_addr_en`=1. It is 0 for any other address.
- R5: A `cmd_restore` or `cmd_mfr_reset` strobe in the passing or failed state gives `crc_start`=1 and `run_en`=0 on the next cycle. These two strobes are honoured whatever the temperature.
- R6: `temp_code` is signed, in units of 0.25 °C. A code above 520 (130 °C) sets `nvm_locked` two cycles later. A code below 500 (125 °C) clears it two cycles later. Codes from 500 to 520 leave it unchanged, and exactly 520 does not lock.
- R7: A `cmd_store` or `cmd_nvm_op` strobe while `nvm_locked`=1 is dropped. The next cycle shows `cmd_reject`=1 with `store_go`=0 and `nvm_op_go`=0, and `cmd_reject` falls back to 0 a cycle after that.
- R8: A `cmd_clear` or `cmd_w1c` strobe in the failed state starts a new check (`crc_start`=1 next cycle). If that check passes, `crc_err_flag`, `cml_flag` and `recov_addr_en` return to 0, `alert_n` to 1, and `run_en` to 1.
- R9: If the check started by a clear or write-one request fails, `fault_dead`=1 and `crc_err_flag`=1 and `alert_n`=0 remain one cycle later.
- R10: While `fault_dead`=1, restore, soft-reset, store, clear and write-one strobes cause no `crc_start`, no `store_go` and no change of outputs until `rst`.
- R11: A `cmd_store` or `cmd_nvm_op` strobe while unlocked and not permanently faulted gives a one-cycle `store_go` or `nvm_op_go` pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| temp_code | input | TEMP_W | Signed die temperature, 0.25 °C per LSB |
| cmd_restore | input | 1 | Reload-store strobe |
| cmd_mfr_reset | input | 1 | Soft-reset strobe |
| cmd_store | input | 1 | Store-to-memory strobe |
| cmd_nvm_op | input | 1 | Any other memory operation strobe |
| cmd_clear | input | 1 | Clear-faults strobe |
| cmd_w1c | input | 1 | Write of one to the CRC-error bit |
| crc_done | input | 1 | CRC engine finished |
| crc_ok | input | 1 | CRC result, valid with crc_done |
| bus_addr | input | 7 | Address seen on the management bus |
| crc_start | output | 1 | Request to the CRC engine |
| run_en | output | 1 | Enable for both PWM channels |
| alert_n | output | 1 | Active-low alert |
| cml_flag | output | 1 | Comm/memory fault flag for status byte and word |
| crc_err_flag | output | 1 | Memory CRC error bit of manufacturer status |
| recov_addr_en | output | 1 | Recovery address enabled |
| addr_hit | output | 1 | Device answers bus_addr |
| nvm_locked | output | 1 | Thermal lockout active |
| store_go | output | 1 | Accepted store pulse |
| nvm_op_go | output | 1 | Accepted memory operation pulse |
| cmd_reject | output | 1 | Blocked command pulse |
| fault_dead | output | 1 | Permanent fault latched |

## Verification
Command responses and CRC results are registered once. Their outputs are therefore due one cycle after the strobe or `crc_done`, and each check reads them at the falling edge right after that rising edge. The thermal lockout passes through two registers, so each temperature test reads `nvm_locked` one falling edge after the change, where it must still be unchanged, and again two edges after, where it must have moved. `addr_hit` is combinational and is read in the same half-cycle in which `bus_addr` is driven. Dropped or ignored commands are checked on the outputs one cycle later, and pulses are checked again a cycle after that to confirm they last only one cycle.

// File: rtl/nvg_pkg.sv
package nvg_pkg;

    localparam int BUS_ADDR_W     = 7;
    localparam int TEMP_FRAC_BITS = 2;

    localparam logic [BUS_ADDR_W-1:0] GLOBAL_ADDR_A = 7'h5A;
    localparam logic [BUS_ADDR_W-1:0] GLOBAL_ADDR_B = 7'h5B;
    localparam logic [BUS_ADDR_W-1:0] RECOVERY_ADDR = 7'h7C;

    typedef enum logic [2:0] {
        SUP_RESET_WAIT = 3'd0,
        SUP_CHECKING   = 3'd1,
        SUP_OK         = 3'd2,
        SUP_CRC_FAIL   = 3'd3,
        SUP_DEAD       = 3'd4
    } sup_state_e;

    // Requests that steer the supervisor state machine
    typedef struct packed {
        logic reload;   // restore or soft reset
        logic clear;    // clear-faults or write-one on the error bit
    } sup_req_t;

    // Degrees Celsius to fixed-point temperature code
    function automatic int deg_to_q(input int deg);
        return deg * (1 << TEMP_FRAC_BITS);
    endfunction

endpackage

// File: rtl/nvg_thermal.sv
module nvg_thermal #(
    parameter int TEMP_W = 16,
    parameter logic signed [TEMP_W-1:0] HOT_CODE  = 16'sd520,
    parameter logic signed [TEMP_W-1:0] COOL_CODE = 16'sd500
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [TEMP_W-1:0] temp,
    output logic                     locked
);
    logic hot_q;
    logic cool_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hot_q  <= 1'b0;
            cool_q <= 1'b0;
            locked <= 1'b0;
        end else begin
            hot_q  <= (temp > HOT_CODE);
            cool_q <= (temp < COOL_CODE);
            if (hot_q)
                locked <= 1'b1;
            else if (cool_q)
                locked <= 1'b0;
        end
    end

    a_r6_hot_sets_lock: assert property (@(posedge clk) disable iff (rst)
        hot_q |=> locked);
    a_r6_cool_clears_lock: assert property (@(posedge clk) disable iff (rst)
        cool_q |=> !locked);
    a_r6_band_holds: assert property (@(posedge clk) disable iff (rst)
        (!hot_q && !cool_q) |=> $stable(locked));

endmodule

// File: rtl/nvg_cmd_gate.sv
module nvg_cmd_gate (
    input  logic clk,
    input  logic rst,
    input  logic locked,
    input  logic dead,
    input  logic store_req,
    input  logic op_req,
    output logic store_go,
    output logic op_go,
    output logic reject
);
    logic any_req;
    assign any_req = store_req | op_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_go <= 1'b0;
            op_go    <= 1'b0;
            reject   <= 1'b0;
        end else begin
            store_go <= store_req & ~locked & ~dead;
            op_go    <= op_req    & ~locked & ~dead;
            reject   <= any_req   &  locked & ~dead;
        end
    end

    a_r7_locked_drops: assert property (@(posedge clk) disable iff (rst)
        (any_req && locked && !dead) |=> (reject && !store_go && !op_go));
    a_r11_open_passes: assert property (@(posedge clk) disable iff (rst)
        (store_req && !locked && !dead) |=> (store_go && !reject));
    a_r10_dead_silent: assert property (@(posedge clk) disable iff (rst)
        dead |=> (!store_go && !op_go && !reject));

endmodule

// File: rtl/nvg_fsm.sv
module nvg_fsm
    import nvg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sup_req_t   req,
    input  logic       crc_done,
    input  logic       crc_ok,
    output sup_state_e state,
    output logic       err_q,
    output logic       crc_start
);
    sup_state_e nxt;
    logic       retry_q;
    logic       check_end;

    assign check_end = (state == SUP_CHECKING) && crc_done;
    assign crc_start = (state == SUP_RESET_WAIT) && !rst;

    always_comb begin
        nxt = state;
        unique case (state)
            SUP_RESET_WAIT: nxt = SUP_CHECKING;
            SUP_CHECKING:
                if (crc_done)
                    nxt = crc_ok ? SUP_OK : (retry_q ? SUP_DEAD : SUP_CRC_FAIL);
            SUP_OK:
                if (req.reload) nxt = SUP_RESET_WAIT;
            SUP_CRC_FAIL:
                if (req.reload || req.clear) nxt = SUP_RESET_WAIT;
            SUP_DEAD: nxt = SUP_DEAD;
            default: nxt = SUP_RESET_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SUP_RESET_WAIT;
            err_q   <= 1'b0;
            retry_q <= 1'b0;
        end else begin
            state <= nxt;
            if (check_end) begin
                err_q <= !crc_ok;
                if (crc_ok) retry_q <= 1'b0;
            end
            if (state == SUP_CRC_FAIL) begin
                if (req.reload)
                    retry_q <= 1'b0;
                else if (req.clear)
                    retry_q <= 1'b1;
            end
        end
    end

    a_r2_pass_releases: assert property (@(posedge clk) disable iff (rst)
        (check_end && crc_ok) |=> (state == SUP_OK && !err_q));
    a_r3_fail_latches: assert property (@(posedge clk) disable iff (rst)
        (check_end && !crc_ok) |=> (err_q && state != SUP_OK));
    a_r5_reload_restarts: assert property (@(posedge clk) disable iff (rst)
        (state == SUP_OK && req.reload) |=> (state == SUP_RESET_WAIT));
    a_r8_clear_rechecks: assert property (@(posedge clk) disable iff (rst)
        (state == SUP_CRC_FAIL && req.clear) |=> (state == SUP_RESET_WAIT));
    a_r10_dead_holds: assert property (@(posedge clk) disable iff (rst)
        (state == SUP_DEAD) |=> (state == SUP_DEAD && err_q));

endmodule

// File: rtl/nvg_addr.sv
module nvg_addr
    import nvg_pkg::*;
#(
    parameter logic [BUS_ADDR_W-1:0] OWN_ADDR = 7'h40
) (
    input  logic [BUS_ADDR_W-1:0] addr,
    input  logic                  recov_en,
    output logic                  hit
);
    logic fixed_hit;

    assign fixed_hit = (addr == OWN_ADDR) || (addr == GLOBAL_ADDR_A) ||
                       (addr == GLOBAL_ADDR_B);
    assign hit = fixed_hit || (recov_en && (addr == RECOVERY_ADDR));

endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
    import nvg_pkg::*;
#(
    parameter int TEMP_W   = 16,
    parameter int HOT_DEG  = 130,
    parameter int COOL_DEG = 125,
    parameter logic [6:0] OWN_ADDR = 7'h40
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [TEMP_W-1:0] temp_code,
    input  logic                     cmd_restore,
    input  logic                     cmd_mfr_reset,
    input  logic                     cmd_store,
    input  logic                     cmd_nvm_op,
    input  logic                     cmd_clear,
    input  logic                     cmd_w1c,
    input  logic                     crc_done,
    input  logic                     crc_ok,
    input  logic [6:0]               bus_addr,
    output logic                     crc_start,
    output logic                     run_en,
    output logic                     alert_n,
    output logic                     cml_flag,
    output logic                     crc_err_flag,
    output logic                     recov_addr_en,
    output logic                     addr_hit,
    output logic                     nvm_locked,
    output logic                     store_go,
    output logic                     nvm_op_go,
    output logic                     cmd_reject,
    output logic                     fault_dead
);
    localparam logic signed [TEMP_W-1:0] HOT_CODE  = TEMP_W'(deg_to_q(HOT_DEG));
    localparam logic signed [TEMP_W-1:0] COOL_CODE = TEMP_W'(deg_to_q(COOL_DEG));

    sup_state_e state;
    sup_req_t   req;
    logic       err_q;

    assign req.reload = cmd_restore | cmd_mfr_reset;
    assign req.clear  = cmd_clear | cmd_w1c;

    nvg_thermal #(
        .TEMP_W   (TEMP_W),
        .HOT_CODE (HOT_CODE),
        .COOL_CODE(COOL_CODE)
    ) u_thermal (
        .clk   (clk),
        .rst   (rst),
        .temp  (temp_code),
        .locked(nvm_locked)
    );

    nvg_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .crc_done (crc_done),
        .crc_ok   (crc_ok),
        .state    (state),
        .err_q    (err_q),
        .crc_start(crc_start)
    );

    nvg_cmd_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .locked   (nvm_locked),
        .dead     (fault_dead),
        .store_req(cmd_store),
        .op_req   (cmd_nvm_op),
        .store_go (store_go),
        .op_go    (nvm_op_go),
        .reject   (cmd_reject)
    );

    nvg_addr #(.OWN_ADDR(OWN_ADDR)) u_addr (
        .addr    (bus_addr),
        .recov_en(recov_addr_en),
        .hit     (addr_hit)
    );

    assign run_en        = (state == SUP_OK);
    assign fault_dead    = (state == SUP_DEAD);
    assign crc_err_flag  = err_q;
    assign cml_flag      = err_q;
    assign recov_addr_en = err_q;
    assign alert_n       = ~err_q;

    a_r1_run_needs_clean: assert property (@(posedge clk) disable iff (rst)
        run_en |-> (alert_n && !crc_err_flag && !crc_start));
    a_r4_recovery_addr_gated: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RECOVERY_ADDR && OWN_ADDR != RECOVERY_ADDR && addr_hit) |-> recov_addr_en);
    a_r9_dead_alerts: assert property (@(posedge clk) disable iff (rst)
        fault_dead |-> (!alert_n && !run_en));

endmodule

// File: tb/sim_nvm_guard.sv
module sim_nvm_guard;
    localparam time CLK_PERIOD = 10ns;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] temp_code = 16'sd100;
    logic cmd_restore = 0, cmd_mfr_reset = 0, cmd_store = 0, cmd_nvm_op = 0;
    logic cmd_clear = 0, cmd_w1c = 0, crc_done = 0, crc_ok = 0;
    logic [6:0] bus_addr = 7'h00;
    logic crc_start, run_en, alert_n, cml_flag, crc_err_flag, recov_addr_en;
    logic addr_hit, nvm_locked, store_go, nvm_op_go, cmd_reject, fault_dead;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_guard u0 (
        .clk(clk), .rst(rst), .temp_code(temp_code),
        .cmd_restore(cmd_restore), .cmd_mfr_reset(cmd_mfr_reset),
        .cmd_store(cmd_store), .cmd_nvm_op(cmd_nvm_op),
        .cmd_clear(cmd_clear), .cmd_w1c(cmd_w1c),
        .crc_done(crc_done), .crc_ok(crc_ok), .bus_addr(bus_addr),
        .crc_start(crc_start), .run_en(run_en), .alert_n(alert_n),
        .cml_flag(cml_flag), .crc_err_flag(crc_err_flag),
        .recov_addr_en(recov_addr_en), .addr_hit(addr_hit),
        .nvm_locked(nvm_locked), .store_go(store_go), .nvm_op_go(nvm_op_go),
        .cmd_reject(cmd_reject), .fault_dead(fault_dead)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One strobe: 0 restore, 1 mfr reset, 2 store, 3 nvm op, 4 clear, 5 w1c
    task automatic strobe(input int which);
        cmd_restore   = (which == 0);
        cmd_mfr_reset = (which == 1);
        cmd_store     = (which == 2);
        cmd_nvm_op    = (which == 3);
        cmd_clear     = (which == 4);
        cmd_w1c       = (which == 5);
        @(negedge clk);
        cmd_restore = 0; cmd_mfr_reset = 0; cmd_store = 0;
        cmd_nvm_op = 0; cmd_clear = 0; cmd_w1c = 0;
    endtask

    // CRC engine model: answer the pending request with the given result
    task automatic crc_answer(input logic ok);
        for (int i = 0; i < 20 && !crc_start; i++) @(negedge clk);
        chk("R1", "crc_start seen", crc_start, 1);
        @(negedge clk);
        crc_done = 1; crc_ok = ok;
        @(negedge clk);
        crc_done = 0; crc_ok = 0;
    endtask

    task automatic t_reset_and_pass();
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1", "run_en in reset", run_en, 0);
        chk("R1", "alert_n in reset", alert_n, 1);
        rst = 0;
        #1;
        chk("R1", "crc_start after reset", crc_start, 1);
        chk("R1", "crc_err_flag after reset", crc_err_flag, 0);
        chk("R1", "nvm_locked after reset", nvm_locked, 0);
        crc_answer(1);
        chk("R2", "run_en after pass", run_en, 1);
        chk("R2", "crc_err_flag after pass", crc_err_flag, 0);
        chk("R2", "crc_start idle", crc_start, 0);
    endtask

    task automatic t_addr_normal();
        bus_addr = 7'h5A; #1; chk("R4", "hit 5A", addr_hit, 1);
        bus_addr = 7'h5B; #1; chk("R4", "hit 5B", addr_hit, 1);
        bus_addr = 7'h40; #1; chk("R4", "hit own", addr_hit, 1);
        bus_addr = 7'h7C; #1; chk("R4", "7C closed", addr_hit, 0);
        bus_addr = 7'h11; #1; chk("R4", "other miss", addr_hit, 0);
        bus_addr = 7'h00;
    endtask

    task automatic t_store_open();
        strobe(2);
        chk("R11", "store_go", store_go, 1);
        chk("R11", "no reject", cmd_reject, 0);
        @(negedge clk);
        chk("R11", "store_go one cycle", store_go, 0);
        strobe(3);
        chk("R11", "nvm_op_go", nvm_op_go, 1);
    endtask

    task automatic t_thermal();
        temp_code = 16'sd521;
        @(negedge clk);
        chk("R6", "lock not yet", nvm_locked, 0);
        @(negedge clk);
        chk("R6", "lock above 130C", nvm_locked, 1);
        temp_code = 16'sd510;
        repeat (3) @(negedge clk);
        chk("R6", "lock held in band", nvm_locked, 1);
        strobe(2);
        chk("R7", "store blocked", store_go, 0);
        chk("R7", "reject pulse", cmd_reject, 1);
        @(negedge clk);
        chk("R7", "reject one cycle", cmd_reject, 0);
        strobe(3);
        chk("R7", "op blocked", nvm_op_go, 0);
        chk("R7", "op reject", cmd_reject, 1);
        strobe(1);
        chk("R5", "soft reset while hot", crc_start, 1);
        chk("R5", "run dropped", run_en, 0);
        crc_answer(1);
        chk("R2", "run after reload", run_en, 1);
        temp_code = 16'sd499;
        @(negedge clk);
        chk("R6", "still locked", nvm_locked, 1);
        @(negedge clk);
        chk("R6", "unlock below 125C", nvm_locked, 0);
        temp_code = 16'sd520;
        repeat (3) @(negedge clk);
        chk("R6", "520 does not lock", nvm_locked, 0);
        temp_code = -16'sd160;
        repeat (3) @(negedge clk);
        chk("R6", "negative temp", nvm_locked, 0);
        temp_code = 16'sd100;
    endtask

    task automatic t_fail_recover();
        strobe(0);
        chk("R5", "restore starts check", crc_start, 1);
        crc_answer(0);
        chk("R3", "err flag", crc_err_flag, 1);
        chk("R3", "cml flag", cml_flag, 1);
        chk("R3", "alert low", alert_n, 0);
        chk("R3", "run low", run_en, 0);
        chk("R3", "recovery enabled", recov_addr_en, 1);
        bus_addr = 7'h7C; #1;
        chk("R4", "7C open on error", addr_hit, 1);
        bus_addr = 7'h00;
        strobe(2);
        chk("R11", "repair store", store_go, 1);
        strobe(4);
        chk("R8", "clear rechecks", crc_start, 1);
        crc_answer(1);
        chk("R8", "err cleared", crc_err_flag, 0);
        chk("R8", "cml cleared", cml_flag, 0);
        chk("R8", "alert released", alert_n, 1);
        chk("R8", "recovery closed", recov_addr_en, 0);
        chk("R8", "run restored", run_en, 1);
    endtask

    task automatic t_dead();
        strobe(0);
        crc_answer(0);
        chk("R3", "first fail", crc_err_flag, 1);
        strobe(5);
        chk("R8", "w1c rechecks", crc_start, 1);
        crc_answer(0);
        chk("R9", "dead latched", fault_dead, 1);
        chk("R9", "err stays", crc_err_flag, 1);
        chk("R9", "alert low", alert_n, 0);
        for (int k = 0; k < 6; k++) begin
            if (k == 3) continue;
            strobe(k);
            chk("R10", "no crc_start", crc_start, 0);
            chk("R10", "no store_go", store_go, 0);
            chk("R10", "still dead", fault_dead, 1);
            chk("R10", "run off", run_en, 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_and_pass();
        t_addr_normal();
        t_store_open();
        t_thermal();
        t_fail_recover();
        t_dead();
        t_reset_and_pass();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule